// File: doc/BRIEF.md
# Character Timing Generator for a CRT Controller

This block is the horizontal timing and memory-address core of a character-based CRT controller. The host programs a small bank of 8-bit timing registers through a register-select and data port. A character counter runs along each line and produces the display-enable and horizontal-sync outputs. At the same time a 14-bit refresh address walks the character memory. A coarse row counter drives line-visible and vertical sync. Interlace, cursor and light-pen logic are not part of this block.

Each character cycle takes two clock periods. In the first period (phase 1) the outputs present the current bus state. The clock edge that ends phase 1 applies every counter, sync and address update, so a downstream consumer sees new sync levels during phase 2 of the same character rather than at the start of the next one. The sync width check runs in the same step that starts sync, so a programmed width of zero suppresses the pulse entirely. Register contents survive reset. Reset only clears the counters, the sync flag, the refresh address and the phase.

Top module: `crtc_char_timer`

## Requirements
- R1: `phase2` is 0 in the first clock after reset and toggles on every clock. All timing state changes only on the edge that ends phase 1, so `ref_addr` and `hsync` are unchanged across the edge that ends phase 2.
- R2: In a step where the character count equals register 2, the width counter is cleared and sync is asserted. While sync is asserted, each step sets it to "width counter differs from the low 4 bits of register 3" and then increments the counter modulo 16. With a width W > 0, `hsync` is high for exactly W consecutive characters.
- R3: A width of 0 (low 4 bits of register 3) keeps `hsync` low, even in the step where the count matches register 2. The upper 4 bits of register 3 have no effect.
- R4: Every step that is not an end of line advances `ref_addr` by one, modulo 2^14.
- R5: A step where the character count equals register 0 is an end of line. The count returns to 0, so a line lasts register0+1 characters. In any other step the count increments.
- R6: `disp_en` is the AND of a character-visible flag and a line-visible flag. The character-visible flag clears in the step where the count equals register 1, and is set again at end of line; end of line takes precedence.
- R7: In the step where the count equals register 1, the current `ref_addr` is latched. At an end of line that does not close the frame, `ref_addr` loads this latched value.
- R8: A row counter advances at each end of line. When it equals the low 7 bits of register 4, it returns to 0 and `ref_addr` reloads the start address {register12[5:0], register13}.
- R9: The line-visible flag is "row count < low 7 bits of register 6". `vsync` is high while the row count equals the low 7 bits of register 7.
- R10: With `rd_status` low, `rd_data` returns the stored register for indices 12 to 17 and 0xFF for every other index (0 to 31). With `rd_status` high it returns 0xFF. Writes to indices 18 to 31 are ignored.
- R11: A synchronous active-high `rst` clears the character count, width counter, `hsync`, `ref_addr`, the latched line address, the row count and the phase, and sets the character-visible flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two periods per character |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 5 | Register index for writes and reads |
| reg_wr | input | 1 | Write strobe, data stored on the clock edge |
| reg_wdata | input | 8 | Write data |
| rd_status | input | 1 | Selects the status port on `rd_data` |
| rd_data | output | 8 | Register or status read data (combinational) |
| phase2 | output | 1 | High during the second half of each character |
| disp_en | output | 1 | Display enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync (one row) |
| ref_addr | output | 14 | Character memory refresh address |

## Verification
A wrong width counter or start compare shows up on `hsync` within one line: the pulse starts late, has the wrong length, or fails to vanish for width zero. A slip in the character counter or the visible flag shows up on `disp_en` and on the row-start `ref_addr` at the next end of line. A bad latched line address or start-address reload stays hidden until the next row or frame boundary. From then on every `ref_addr` value is wrong. The bench therefore runs each configuration through at least two full frames and compares every output in both phases of every character.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

   typedef enum logic {
      PH_ONE = 1'b0,
      PH_TWO = 1'b1
   } phase_e;

   // register indices whose numbering the host and readback window depend on
   localparam int IDX_HTOT  = 0;
   localparam int IDX_HDISP = 1;
   localparam int IDX_HSPOS = 2;
   localparam int IDX_SWID  = 3;
   localparam int IDX_VTOT  = 4;
   localparam int IDX_VDISP = 6;
   localparam int IDX_VSPOS = 7;
   localparam int IDX_SAH   = 12;
   localparam int IDX_SAL   = 13;

endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile #(
   parameter int DATA_W = 8,
   parameter int NREG   = 18,
   parameter int SEL_W  = 5,
   parameter int RD_LO  = 12,
   parameter int RD_HI  = 17
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [SEL_W-1:0]         sel,
   input  logic [DATA_W-1:0]        wdata,
   input  logic                     rd_status,
   output logic [DATA_W-1:0]        rd_data,
   output logic [NREG*DATA_W-1:0]   regs_o
);

   localparam int SEL_SPAN = 1 << SEL_W;

   if (NREG > SEL_SPAN) begin : g_bad_nreg
      $error("crtc_regfile: NREG exceeds the select range");
   end
   if (RD_HI >= NREG || RD_LO > RD_HI) begin : g_bad_window
      $error("crtc_regfile: readable window outside the register bank");
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && sel == SEL_W'(g)) q <= wdata;
      end
      assign regs_o[g*DATA_W +: DATA_W] = q;
   end

   always_comb begin
      rd_data = '1;
      if (!rd_status) begin
         for (int i = RD_LO; i <= RD_HI; i++) begin
            if (sel == SEL_W'(i)) rd_data = regs_o[i*DATA_W +: DATA_W];
         end
      end
   end

endmodule

// File: rtl/crtc_hcount.sv
module crtc_hcount #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  logic [CNT_W-1:0] htot,
   input  logic [CNT_W-1:0] hdisp,
   input  logic [CNT_W-1:0] hspos,
   output logic [CNT_W-1:0] cnt_o,
   output logic             cvis_o,
   output logic             eol_o,
   output logic             vis_end_o,
   output logic             hs_start_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             cvis_q;

   assign eol_o      = (cnt_q == htot);
   assign vis_end_o  = (cnt_q == hdisp);
   assign hs_start_o = (cnt_q == hspos);
   assign cnt_o      = cnt_q;
   assign cvis_o     = cvis_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         cvis_q <= 1'b1;
      end else if (step) begin
         if (eol_o) begin
            cnt_q  <= '0;
            cvis_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            if (vis_end_o) cvis_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/crtc_hsync.sv
module crtc_hsync #(
   parameter int SYNC_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic              start,
   input  logic [SYNC_W-1:0] width,
   output logic              hsync_o
);

   logic [SYNC_W-1:0] wcnt_q, wcnt_tmp, wcnt_n;
   logic              hs_q, hs_tmp, hs_n;

   // start is applied first, then the width test sees the cleared counter
   always_comb begin
      wcnt_tmp = start ? '0 : wcnt_q;
      hs_tmp   = start | hs_q;
      if (hs_tmp) begin
         hs_n   = (wcnt_tmp != width);
         wcnt_n = wcnt_tmp + 1'b1;
      end else begin
         hs_n   = 1'b0;
         wcnt_n = wcnt_q;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wcnt_q <= '0;
         hs_q   <= 1'b0;
      end else if (step) begin
         wcnt_q <= wcnt_n;
         hs_q   <= hs_n;
      end
   end

   assign hsync_o = hs_q;

endmodule

// File: rtl/crtc_addrgen.sv
module crtc_addrgen #(
   parameter int ADDR_W = 14,
   parameter int LINE_W = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic              eol,
   input  logic              vis_end,
   input  logic [LINE_W-1:0] vtot,
   input  logic [LINE_W-1:0] vdisp,
   input  logic [LINE_W-1:0] vspos,
   input  logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] ref_addr_o,
   output logic              line_vis_o,
   output logic              vsync_o
);

   logic [ADDR_W-1:0] ra_q, row_q, row_n;
   logic [LINE_W-1:0] line_q;

   assign row_n = vis_end ? ra_q : row_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ra_q   <= '0;
         row_q  <= '0;
         line_q <= '0;
      end else if (step) begin
         row_q <= row_n;
         if (eol) begin
            if (line_q == vtot) begin
               line_q <= '0;
               ra_q   <= start_addr;
            end else begin
               line_q <= line_q + 1'b1;
               ra_q   <= row_n;
            end
         end else begin
            ra_q <= ra_q + 1'b1;
         end
      end
   end

   assign ref_addr_o = ra_q;
   assign line_vis_o = (line_q < vdisp);
   assign vsync_o    = (line_q == vspos);

endmodule

// File: rtl/crtc_char_timer.sv
module crtc_char_timer #(
   parameter int DATA_W = 8,
   parameter int NREG   = 18,
   parameter int SEL_W  = 5,
   parameter int ADDR_W = 14,
   parameter int SYNC_W = 4,
   parameter int LINE_W = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              rd_status,
   output logic [DATA_W-1:0] rd_data,
   output logic              phase2,
   output logic              disp_en,
   output logic              hsync,
   output logic              vsync,
   output logic [ADDR_W-1:0] ref_addr
);
   import crtc_pkg::*;

   localparam int HI_W = ADDR_W - DATA_W;

   if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_addr
      $error("crtc_char_timer: ADDR_W must lie between DATA_W+1 and 2*DATA_W");
   end
   if (SYNC_W > DATA_W || LINE_W > DATA_W) begin : g_bad_field
      $error("crtc_char_timer: field wider than a register");
   end
   if (NREG <= IDX_SAL) begin : g_bad_bank
      $error("crtc_char_timer: register bank too small");
   end

   logic [NREG*DATA_W-1:0] reg_bus;
   phase_e                 ph_q;
   logic                   step;
   logic [DATA_W-1:0]      char_cnt;
   logic                   cvis, eol, vis_end, hs_start, line_vis;
   logic [SYNC_W-1:0]      hs_width;
   logic [ADDR_W-1:0]      start_addr;
   logic                   unused_regs;

   assign unused_regs = ^reg_bus;
   assign hs_width    = reg_bus[IDX_SWID*DATA_W +: SYNC_W];
   assign start_addr  = {reg_bus[IDX_SAH*DATA_W +: HI_W], reg_bus[IDX_SAL*DATA_W +: DATA_W]};

   always_ff @(posedge clk) begin
      if (rst) ph_q <= PH_ONE;
      else     ph_q <= (ph_q == PH_ONE) ? PH_TWO : PH_ONE;
   end
   assign step   = (ph_q == PH_ONE);
   assign phase2 = (ph_q == PH_TWO);

   crtc_regfile #(
      .DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W), .RD_LO(12), .RD_HI(17)
   ) u_regs (
      .clk(clk), .wr_en(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
      .rd_status(rd_status), .rd_data(rd_data), .regs_o(reg_bus)
   );

   crtc_hcount #(.CNT_W(DATA_W)) u_hcnt (
      .clk(clk), .rst(rst), .step(step),
      .htot(reg_bus[IDX_HTOT*DATA_W +: DATA_W]),
      .hdisp(reg_bus[IDX_HDISP*DATA_W +: DATA_W]),
      .hspos(reg_bus[IDX_HSPOS*DATA_W +: DATA_W]),
      .cnt_o(char_cnt), .cvis_o(cvis), .eol_o(eol),
      .vis_end_o(vis_end), .hs_start_o(hs_start)
   );

   crtc_hsync #(.SYNC_W(SYNC_W)) u_hs (
      .clk(clk), .rst(rst), .step(step), .start(hs_start),
      .width(hs_width), .hsync_o(hsync)
   );

   crtc_addrgen #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_addr (
      .clk(clk), .rst(rst), .step(step), .eol(eol), .vis_end(vis_end),
      .vtot(reg_bus[IDX_VTOT*DATA_W +: LINE_W]),
      .vdisp(reg_bus[IDX_VDISP*DATA_W +: LINE_W]),
      .vspos(reg_bus[IDX_VSPOS*DATA_W +: LINE_W]),
      .start_addr(start_addr), .ref_addr_o(ref_addr),
      .line_vis_o(line_vis), .vsync_o(vsync)
   );

   assign disp_en = cvis & line_vis;

endmodule

// File: rtl/crtc_char_timer_chk.sv
module crtc_char_timer_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 14,
   parameter int SYNC_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              phase2,
   input logic              hs_start,
   input logic [SYNC_W-1:0] hs_width,
   input logic              hsync,
   input logic              eol,
   input logic [DATA_W-1:0] char_cnt,
   input logic [ADDR_W-1:0] ref_addr
);

   AST_PHASE_RISE: assert property (@(posedge clk) disable iff (rst)
      !phase2 |=> phase2); // R1
   AST_PHASE_FALL: assert property (@(posedge clk) disable iff (rst)
      phase2 |=> !phase2); // R1
   AST_HOLD_IN_PHASE2: assert property (@(posedge clk) disable iff (rst)
      phase2 |=> ($stable(ref_addr) && $stable(hsync))); // R1
   AST_HS_START: assert property (@(posedge clk) disable iff (rst)
      (!phase2 && hs_start && hs_width != '0) |=> hsync); // R2
   AST_HS_ZERO_WIDTH: assert property (@(posedge clk) disable iff (rst)
      (!phase2 && hs_start && hs_width == '0) |=> !hsync); // R3
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
      (!phase2 && !eol) |=> (ref_addr == ADDR_W'($past(ref_addr) + 1'b1))); // R4
   AST_EOL_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (!phase2 && eol) |=> (char_cnt == '0)); // R5

endmodule

bind crtc_char_timer crtc_char_timer_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_W(SYNC_W)
) u_chk (
   .clk(clk), .rst(rst), .phase2(phase2), .hs_start(hs_start),
   .hs_width(hs_width), .hsync(hsync), .eol(eol),
   .char_cnt(char_cnt), .ref_addr(ref_addr)
);

// File: tb/tb_crtc_char_timer.sv
module tb_crtc_char_timer;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  reg_sel = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic        rd_status = 1'b0;
   logic [7:0]  rd_data;
   logic        phase2, disp_en, hsync, vsync;
   logic [13:0] ref_addr;

   crtc_char_timer dut (
      .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .rd_status(rd_status), .rd_data(rd_data),
      .phase2(phase2), .disp_en(disp_en), .hsync(hsync), .vsync(vsync),
      .ref_addr(ref_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0, hs_seen = 0;
   bit done = 1'b0;

   // register mirror and reference model state
   logic [7:0]  rg [0:17];
   logic [7:0]  m_cc;
   logic [3:0]  m_wc;
   logic        m_hs, m_cv;
   logic [13:0] m_ra, m_row;
   logic [6:0]  m_ln;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   function automatic logic exp_disp();
      return m_cv && (m_ln < rg[6][6:0]);
   endfunction

   function automatic logic exp_vs();
      return m_ln == rg[7][6:0];
   endfunction

   task automatic model_reset();
      m_cc = '0; m_wc = '0; m_hs = 1'b0; m_cv = 1'b1;
      m_ra = '0; m_row = '0; m_ln = '0;
   endtask

   task automatic model_step();
      logic [3:0]  wt;
      logic        ht;
      logic [13:0] rown;
      wt = (m_cc == rg[2]) ? 4'd0 : m_wc;
      ht = (m_cc == rg[2]) | m_hs;
      if (ht) begin
         m_hs = (wt != rg[3][3:0]);
         m_wc = wt + 4'd1;
      end
      rown = (m_cc == rg[1]) ? m_ra : m_row;
      if (m_cc == rg[1]) m_cv = 1'b0;
      if (m_cc == rg[0]) begin
         m_cc = '0;
         m_cv = 1'b1;
         if (m_ln == rg[4][6:0]) begin
            m_ln = '0;
            m_ra = {rg[12][5:0], rg[13]};
         end else begin
            m_ln = m_ln + 7'd1;
            m_ra = rown;
         end
      end else begin
         m_cc = m_cc + 8'd1;
         m_ra = m_ra + 14'd1;
      end
      m_row = rown;
   endtask

   task automatic wr(input int idx, input logic [7:0] val);
      reg_sel = 5'(idx);
      reg_wdata = val;
      reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      if (idx < 18) rg[idx] = val;
   endtask

   task automatic compare(input logic ph);
      chk(phase2 == ph, "R1 phase2", 32'(phase2), 32'(ph));
      chk(hsync == m_hs, "R2,R3 hsync", 32'(hsync), 32'(m_hs));
      chk(ref_addr == m_ra, "R4,R7,R8 ref_addr", 32'(ref_addr), 32'(m_ra));
      chk(disp_en == exp_disp(), "R5,R6 disp_en", 32'(disp_en), 32'(exp_disp()));
      chk(vsync == exp_vs(), "R9 vsync", 32'(vsync), 32'(exp_vs()));
      if (hsync) hs_seen++;
   endtask

   task automatic run_chars(input int n);
      for (int i = 0; i < n; i++) begin
         compare(1'b0);
         model_step();
         @(negedge clk);
         compare(1'b1);
         @(negedge clk);
      end
   endtask

   // program a configuration under reset, release and run two frames
   task automatic config_run(input logic [7:0] r0, r1, r2, r3, r4, r6, r7, r12, r13);
      rst = 1'b1;
      @(negedge clk);
      wr(0, r0); wr(1, r1); wr(2, r2); wr(3, r3); wr(4, r4);
      wr(6, r6); wr(7, r7); wr(12, r12); wr(13, r13);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
      hs_seen = 0;
      // R11: state right after reset
      chk(ref_addr == 14'd0, "R11 reset ref_addr", 32'(ref_addr), 0);
      chk(hsync == 1'b0, "R11 reset hsync", 32'(hsync), 0);
      chk(phase2 == 1'b0, "R11 reset phase2", 32'(phase2), 0);
      run_chars((int'(r0) + 1) * (int'(r4[6:0]) + 1) * 2 + 3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 18; i++) rg[i] = '0;
      repeat (3) @(negedge clk);

      // directed: address wrap past 0x3FFF, start address reload
      config_run(8'd9, 8'd6, 8'd7, 8'hA3, 8'd4, 8'd3, 8'd4, 8'hFF, 8'hF0);
      chk(hs_seen > 0, "R2 sync seen", 32'(hs_seen), 1);

      // directed: zero width, upper nibble set, must never pulse
      config_run(8'd7, 8'd4, 8'd2, 8'hF0, 8'd2, 8'd2, 8'd1, 8'd1, 8'd0);
      chk(hs_seen == 0, "R3 zero width", 32'(hs_seen), 0);

      // directed: sync start at end of line, visible end equal to total, width 15
      config_run(8'd5, 8'd5, 8'd5, 8'h0F, 8'd3, 8'd9, 8'd0, 8'd0, 8'd40);

      // directed: sync at count 0, visible end at 0, width 1
      config_run(8'd3, 8'd0, 8'd0, 8'h01, 8'd1, 8'd1, 8'd1, 8'h3F, 8'hFF);

      // directed: sync position past the total never starts sync
      config_run(8'd4, 8'd2, 8'd9, 8'h05, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0);
      chk(hs_seen == 0, "R2 no start", 32'(hs_seen), 0);

      // constrained random configurations
      for (int k = 0; k < 8; k++) begin
         logic [7:0] r0;
         r0 = 8'(3 + $urandom % 20);
         config_run(r0, 8'($urandom % (r0 + 2)), 8'($urandom % (r0 + 3)),
                    8'($urandom), {1'($urandom), 7'($urandom % 6)},
                    8'($urandom % 7), 8'($urandom % 7), 8'($urandom), 8'($urandom));
      end

      // R10: readback window and ignored writes
      for (int i = 0; i < 32; i++) wr(i, 8'(8'h30 + i));
      for (int i = 0; i < 32; i++) begin
         logic [7:0] e;
         reg_sel = 5'(i);
         rd_status = 1'b0;
         #1;
         e = (i >= 12 && i <= 17) ? rg[i] : 8'hFF;
         chk(rd_data == e, "R10 register read", 32'(rd_data), 32'(e));
         rd_status = 1'b1;
         #1;
         chk(rd_data == 8'hFF, "R10 status read", 32'(rd_data), 32'hFF);
      end
      rd_status = 1'b0;
      // writes to 18..31 ignored: the registers 0..17 still hold their own values
      reg_sel = 5'd13;
      #1;
      chk(rd_data == 8'h3D, "R10 no alias write", 32'(rd_data), 32'h3D);

      done = 1'b1;
      report();
   end

endmodule